// File: doc/BRIEF.md
# Two-Wire Register-Pair Slave Front End

This block is the serial-bus side of a sixteen-line GPIO expander. It watches a two-wire bus (clock line and open-drain data line) with a fast system clock. It finds start, repeated-start and stop conditions and compares the first byte of each transfer with a 7-bit device address taken from an input port. When the address matches, it turns the following bytes into accesses to an external bank of eight 8-bit registers. The first byte of a write is a command that picks the register index. Each later byte goes to the partner register of that pair, so the index toggles its lowest bit instead of counting up. A read is a command write, then a repeated start with the read flag set. The index survives the repeated start, so the read begins at the chosen register and alternates within the pair.

The bank sees three single-cycle signals: a write strobe with an index and a data byte, and a read strobe with an index. Read data comes back on `reg_rdata` in the same cycle. The slave drives the data line only through `sda_oe`, a pull-low enable. Both bus lines pass through a two-flop synchroniser and a three-sample majority vote before any edge is decoded.

The controller has these states: IDLE, ADDR (shift in the address byte), ADDR_ACK, CMD (shift in the command), CMD_ACK, WR (shift in write data), WR_ACK, RD (shift out read data), RD_ACK (sample the master's acknowledge) and SKIP (ignore the bus). The transitions are as follows:
- A start goes from any state to ADDR, and a stop goes from any state to IDLE.
- ADDR goes to ADDR_ACK on a matching address and to SKIP otherwise.
- ADDR_ACK goes to CMD when the R/W flag is 0 and to RD when it is 1.
- CMD goes to CMD_ACK, then to WR. WR and WR_ACK alternate.
- RD goes to RD_ACK. RD_ACK goes back to RD on an acknowledge and to SKIP on a no-acknowledge.

Top module: `gpx_i2c_slave`

## Requirements
- R1: After reset and after any stop condition, `sda_oe`, `reg_wr` and `reg_rd` are all low.
- R2: A start is the data line falling while the clock line is high, and a stop is the data line rising while the clock line is high. Received bits are taken on the clock's rising edge, MSB first. The slave changes `sda_oe` only while the clock line is low.
- R3: The first byte after a start holds the address in bits 7..1 and R/W in bit 0, where 0 means write. When bits 7..1 equal `dev_addr`, the slave pulls the data line low for the whole ninth clock.
- R4: On an address mismatch the slave gives no acknowledge, issues no strobes and leaves the data line released until the next start or stop.
- R5: In a write, the command byte and every data byte are acknowledged. Command values 0x00 to 0x07 select index = command bits 2..0, and each data byte produces exactly one `reg_wr` pulse carrying that index and the byte.
- R6: After each data byte the index toggles bit 0. For example, command 0x03 sends the bytes to indices 3, 2, 3.
- R7: A repeated start with R/W = 1 keeps the command's index. Each byte sent pulses `reg_rd` with its index. The first byte sent is the selected register, and each byte the master acknowledges is followed by the partner register.
- R8: The write strobe is a one-cycle pulse. It appears in the fifth system clock after the clock line falls at the end of the acknowledge clock (two synchroniser flops, two majority samples, one filter register), while the clock line is still low.
- R9: When the master does not acknowledge a read byte, the slave releases the data line and stays released until the next start or stop.
- R10: Command values 0x08 to 0xFF are acknowledged. Their write bytes are acknowledged but produce no `reg_wr`. Reads at such an index return 0xFF and produce no `reg_rd`.
- R11: A pulse one system clock long on either bus line is filtered out. Such a low pulse on the data line while the clock line is high neither aborts the byte nor corrupts it.
- R12: A stop that arrives partway through a data byte discards the partial byte, so no write occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls the data line low |
| dev_addr | input | 7 | Device address compared against the first byte |
| reg_wr | output | 1 | One-cycle write strobe to the register bank |
| reg_rd | output | 1 | One-cycle read strobe to the register bank |
| reg_idx | output | 3 | Register index for the current strobe |
| reg_wdata | output | 8 | Write data, valid with `reg_wr` |
| reg_rdata | input | 8 | Read data from the bank for `reg_idx`, same cycle |

## Verification
Every bus event reaches the controller five system clocks after the pin changes. The write strobe is therefore due in exactly the fifth clock after the master drops the clock line to end the acknowledge clock. The bench counts clocks from its own clock-line fall and checks that number on every strobe. Acknowledge and read bits are sampled in the middle of the clock-high phase, long after the slave has settled. A per-clock monitor compares each write strobe with the bench's queue of expected index and data pairs. In windows where the slave must stay released, the same monitor checks that `sda_oe` is low on every clock.

// File: rtl/gpx_i2c_pkg.sv
package gpx_i2c_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK,
        ST_SKIP
    } bus_state_e;

    function automatic logic majority3(input logic [2:0] v);
        return (v[0] & v[1]) | (v[1] & v[2]) | (v[0] & v[2]);
    endfunction

endpackage

// File: rtl/gpx_line_filter.sv
module gpx_line_filter #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    import gpx_i2c_pkg::*;

    logic [SYNC_STAGES-1:0] sync_q;
    logic [2:0]             win_q;

    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[0] <= 1'b1;
                    else        sync_q[0] <= line_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[g] <= 1'b1;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    // three-sample window, then a registered vote
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q  <= 3'b111;
            line_o <= 1'b1;
        end else begin
            win_q  <= {win_q[1:0], sync_q[SYNC_STAGES-1]};
            line_o <= majority3(win_q);
        end
    end

endmodule

// File: rtl/gpx_bus_events.sv
module gpx_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    always_comb begin
        scl_rise  = scl_f & ~scl_q;
        scl_fall  = ~scl_f & scl_q;
        start_det = scl_f & scl_q & sda_q & ~sda_f;
        stop_det  = scl_f & scl_q & ~sda_q & sda_f;
    end

endmodule

// File: rtl/gpx_i2c_slave.sv
module gpx_i2c_slave #(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int IDX_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [ADDR_W-1:0] dev_addr,
    output logic              reg_wr,
    output logic              reg_rd,
    output logic [IDX_W-1:0]  reg_idx,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata
);
    import gpx_i2c_pkg::*;

    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] LAST_TX  = CNT_W'(DATA_W - 1);

    logic scl_f, sda_f;
    logic scl_rise, scl_fall, start_det, stop_det;

    bus_state_e        state_q, state_d;
    logic [DATA_W-1:0] rx_q;
    logic [DATA_W-1:0] tx_q;
    logic [CNT_W-1:0]  bitcnt_q;
    logic [IDX_W-1:0]  idx_q;
    logic              cmd_ok_q;
    logic              mack_q;

    logic              byte_full;
    logic              addr_hit;
    logic              ld_rd;
    logic [IDX_W-1:0]  ld_idx;
    logic [DATA_W-1:0] ld_byte;

    gpx_line_filter #(.SYNC_STAGES(SYNC_STAGES)) u_scl_filt (
        .clk(clk), .rst_n(rst_n), .line_i(scl_i), .line_o(scl_f)
    );

    gpx_line_filter #(.SYNC_STAGES(SYNC_STAGES)) u_sda_filt (
        .clk(clk), .rst_n(rst_n), .line_i(sda_i), .line_o(sda_f)
    );

    gpx_bus_events u_events (
        .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    assign byte_full = (bitcnt_q == FULL_CNT);
    assign addr_hit  = (rx_q[DATA_W-1 -: ADDR_W] == dev_addr);

    // read byte load: after the address ack, or after a master ack
    assign ld_rd   = scl_fall &&
                     ((state_q == ST_ADDR_ACK && rx_q[0]) ||
                      (state_q == ST_RD_ACK && mack_q));
    assign ld_idx  = (state_q == ST_RD_ACK) ? (idx_q ^ IDX_W'(1)) : idx_q;
    assign ld_byte = cmd_ok_q ? reg_rdata : {DATA_W{1'b1}};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (start_det) begin
            state_d = ST_ADDR;
        end else if (stop_det) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_ADDR:
                    if (scl_fall && byte_full)
                        state_d = addr_hit ? ST_ADDR_ACK : ST_SKIP;
                ST_ADDR_ACK:
                    if (scl_fall) state_d = rx_q[0] ? ST_RD : ST_CMD;
                ST_CMD:
                    if (scl_fall && byte_full) state_d = ST_CMD_ACK;
                ST_CMD_ACK:
                    if (scl_fall) state_d = ST_WR;
                ST_WR:
                    if (scl_fall && byte_full) state_d = ST_WR_ACK;
                ST_WR_ACK:
                    if (scl_fall) state_d = ST_WR;
                ST_RD:
                    if (scl_fall && bitcnt_q == LAST_TX) state_d = ST_RD_ACK;
                ST_RD_ACK:
                    if (scl_fall) state_d = mack_q ? ST_RD : ST_SKIP;
                ST_SKIP: state_d = ST_SKIP;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // datapath: shifters, bit counter, index, command validity
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q     <= '0;
            tx_q     <= '1;
            bitcnt_q <= '0;
            idx_q    <= '0;
            cmd_ok_q <= 1'b0;
            mack_q   <= 1'b0;
        end else if (start_det || stop_det) begin
            bitcnt_q <= '0;
        end else begin
            unique case (state_q)
                ST_ADDR, ST_CMD, ST_WR: begin
                    if (scl_rise && !byte_full) begin
                        rx_q     <= {rx_q[DATA_W-2:0], sda_f};
                        bitcnt_q <= bitcnt_q + 1'b1;
                    end else if (scl_fall && byte_full) begin
                        bitcnt_q <= '0;
                        if (state_q == ST_CMD) begin
                            idx_q    <= rx_q[IDX_W-1:0];
                            cmd_ok_q <= (rx_q[DATA_W-1:IDX_W] == '0);
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (ld_rd) begin
                        tx_q     <= ld_byte;
                        bitcnt_q <= '0;
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall) idx_q <= idx_q ^ IDX_W'(1);
                end
                ST_RD: begin
                    if (scl_fall) begin
                        if (bitcnt_q == LAST_TX) begin
                            bitcnt_q <= '0;
                        end else begin
                            tx_q     <= {tx_q[DATA_W-2:0], 1'b1};
                            bitcnt_q <= bitcnt_q + 1'b1;
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) mack_q <= ~sda_f;
                    if (ld_rd) begin
                        idx_q <= ld_idx;
                        tx_q  <= ld_byte;
                    end
                end
                ST_IDLE, ST_CMD_ACK, ST_SKIP: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        sda_oe    = 1'b0;
        reg_wr    = 1'b0;
        reg_rd    = ld_rd && cmd_ok_q;
        reg_idx   = ld_rd ? ld_idx : idx_q;
        reg_wdata = rx_q;
        unique case (state_q)
            ST_ADDR_ACK, ST_CMD_ACK: sda_oe = 1'b1;
            ST_WR_ACK: begin
                sda_oe = 1'b1;
                reg_wr = scl_fall && cmd_ok_q && !start_det && !stop_det;
            end
            ST_RD:   sda_oe = ~tx_q[DATA_W-1];
            ST_IDLE, ST_ADDR, ST_CMD, ST_WR, ST_RD_ACK, ST_SKIP: ;
            default: ;
        endcase
    end

endmodule

// File: rtl/gpx_i2c_checker.sv
module gpx_i2c_checker (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic scl_f,
    input logic stop_det,
    input logic sda_oe,
    input logic reg_wr,
    input logic reg_rd
);
    // R1: after a stop the data line is released
    p_stop_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // R2: the slave changes the data line only while the clock is low
    p_oe_rise_scl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_f);
    p_oe_fall_scl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> !scl_f);

    // R8: write strobe is one cycle wide and fires with the clock pin low
    p_wr_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);
    p_wr_scl_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> !scl_i);

    // R7: read and write strobes never coincide
    p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_rd));

endmodule

bind gpx_i2c_slave gpx_i2c_checker u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .scl_f(scl_f),
    .stop_det(stop_det), .sda_oe(sda_oe), .reg_wr(reg_wr), .reg_rd(reg_rd)
);

// File: tb/gpx_i2c_slave_tb.sv
module gpx_i2c_slave_tb;

    localparam int H = 20;
    localparam logic [6:0] DEV = 7'h5A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe, reg_wr, reg_rd;
    logic [2:0] reg_idx;
    logic [7:0] reg_wdata, reg_rdata;
    logic       sda_line;

    int checks = 0;
    int errors = 0;
    logic [7:0]  mem [8];
    logic [7:0]  shadow [8];
    logic [10:0] exp_q [$];
    bit   rel_chk = 0;
    int   fall_cnt = 0;
    logic scl_d = 1'b1;
    int   rd_pulses = 0;

    always #10 clk = ~clk;

    assign sda_line  = sda_m & ~sda_oe;
    assign reg_rdata = mem[reg_idx];

    gpx_i2c_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .dev_addr(DEV), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    // behavioural register bank
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) mem[i] <= 8'h00;
        end else if (reg_wr) begin
            mem[reg_idx] <= reg_wdata;
        end
    end

    // clocks since the bench dropped the clock line
    always @(posedge clk) begin
        scl_d <= scl_m;
        if (scl_d && !scl_m) fall_cnt <= 1;
        else                 fall_cnt <= fall_cnt + 1;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-clock comparison against the expected-write queue and release windows
    always @(negedge clk) begin
        if (rst_n) begin
            if (reg_rd) rd_pulses++;
            if (reg_wr) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R5/R10/R12 unexpected write", {reg_idx, reg_wdata}, 0);
                end else begin
                    logic [10:0] e;
                    e = exp_q.pop_front();
                    chk({reg_idx, reg_wdata} == e, "R5/R6 write idx,data",
                        {reg_idx, reg_wdata}, e);
                end
                chk(fall_cnt == 5, "R8 strobe latency", fall_cnt, 5);
            end
            if (rel_chk && sda_oe) chk(0, "R4/R9 line not released", 1, 0);
        end
    end

    task automatic hc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1; scl_m = 1; hc(H);
        sda_m = 0; hc(H);
        scl_m = 0; hc(2);
    endtask

    task automatic bus_rstart();
        sda_m = 1; hc(H);
        scl_m = 1; hc(H);
        sda_m = 0; hc(H);
        scl_m = 0; hc(2);
    endtask

    task automatic bus_stop();
        sda_m = 0; hc(H);
        scl_m = 1; hc(H);
        sda_m = 1; hc(H);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; hc(H);
            scl_m = 1;
            if (glitch && b[i]) begin
                hc(3); sda_m = 0; hc(1); sda_m = 1; hc(H - 4);
            end else begin
                hc(H);
            end
            scl_m = 0; hc(2);
        end
        sda_m = 1; hc(H);
        scl_m = 1; hc(H / 2);
        ack = ~sda_line;
        hc(H / 2);
        scl_m = 0; hc(2);
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        sda_m = 1;
        for (int i = 7; i >= 0; i--) begin
            hc(H);
            scl_m = 1; hc(H / 2);
            b[i] = sda_line;
            hc(H / 2);
            scl_m = 0; hc(2);
        end
        sda_m = mack ? 1'b0 : 1'b1; hc(H);
        scl_m = 1; hc(H);
        scl_m = 0; hc(2);
        sda_m = 1;
    endtask

    task automatic expect_wr(input logic [2:0] idx, input logic [7:0] d);
        exp_q.push_back({idx, d});
        shadow[idx] = d;
    endtask

    task automatic read_check(input logic [7:0] cmd, input int n, input string tag);
        bit a;
        logic [7:0] b;
        logic [7:0] e;
        logic [2:0] idx;
        bus_start();
        send_byte({DEV, 1'b0}, 0, a);
        send_byte(cmd, 0, a);
        bus_rstart();
        send_byte({DEV, 1'b1}, 0, a);
        chk(a, {tag, " read address ack"}, a, 1);
        idx = cmd[2:0];
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, b);
            e = (cmd[7:3] == 0) ? shadow[idx] : 8'hFF;
            chk(b == e, tag, b, e);
            idx[0] = ~idx[0];
        end
        rel_chk = 1;
        hc(H);
        bus_stop();
        rel_chk = 0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        bit a;
        int rd_before;
        for (int i = 0; i < 8; i++) shadow[i] = 8'h00;
        hc(5);
        rst_n = 1;
        hc(3);
        chk(!sda_oe && !reg_wr && !reg_rd, "R1 reset outputs", {sda_oe, reg_wr, reg_rd}, 0);

        // R3 R5 R6: write 3 bytes from index 3
        bus_start();
        send_byte({DEV, 1'b0}, 0, a);
        chk(a, "R3 address ack", a, 1);
        send_byte(8'h03, 0, a);
        chk(a, "R5 command ack", a, 1);
        expect_wr(3'd3, 8'hA5); send_byte(8'hA5, 0, a); chk(a, "R5 data ack", a, 1);
        expect_wr(3'd2, 8'h5A); send_byte(8'h5A, 0, a); chk(a, "R6 data ack", a, 1);
        expect_wr(3'd3, 8'h3C); send_byte(8'h3C, 0, a); chk(a, "R6 data ack", a, 1);
        bus_stop();
        hc(2);
        chk(!sda_oe, "R1 released after stop", sda_oe, 0);
        chk(mem[2] == 8'h5A && mem[3] == 8'h3C, "R6 pair contents", {mem[3], mem[2]}, 16'h3C5A);

        // R7 R9: read starting at index 2, three bytes, last not acknowledged
        rd_before = rd_pulses;
        read_check(8'h02, 3, "R7 read pair alternation");
        chk(rd_pulses - rd_before == 3, "R7 read strobe count", rd_pulses - rd_before, 3);

        // R4: foreign address
        rel_chk = 1;
        bus_start();
        send_byte({DEV ^ 7'h01, 1'b0}, 0, a);
        chk(!a, "R4 no ack on mismatch", a, 0);
        send_byte(8'h03, 0, a);
        chk(!a, "R4 later byte ignored", a, 0);
        send_byte(8'h11, 0, a);
        chk(!a, "R4 later byte ignored", a, 0);
        bus_stop();
        rel_chk = 0;
        chk(mem[3] == 8'h3C, "R4 bank untouched", mem[3], 8'h3C);

        // R10: out-of-range command
        bus_start();
        send_byte({DEV, 1'b0}, 0, a);
        send_byte(8'h09, 0, a);
        chk(a, "R10 command ack", a, 1);
        send_byte(8'h77, 0, a);
        chk(a, "R10 data ack", a, 1);
        bus_stop();
        chk(mem[1] == 8'h00, "R10 write discarded", mem[1], 0);
        rd_before = rd_pulses;
        read_check(8'h0C, 2, "R10 read returns FF");
        chk(rd_pulses == rd_before, "R10 no read strobe", rd_pulses - rd_before, 0);

        // R12: stop in the middle of a data byte
        bus_start();
        send_byte({DEV, 1'b0}, 0, a);
        send_byte(8'h04, 0, a);
        for (int i = 0; i < 4; i++) begin
            sda_m = i[0]; hc(H);
            scl_m = 1; hc(H);
            scl_m = 0; hc(2);
        end
        bus_stop();
        chk(mem[4] == 8'h00, "R12 partial byte discarded", mem[4], 0);
        read_check(8'h04, 1, "R12 read after abort");

        // R11: one-clock low pulses on the data line while the clock is high
        bus_start();
        send_byte({DEV, 1'b0}, 0, a);
        send_byte(8'h05, 0, a);
        expect_wr(3'd5, 8'hC3);
        send_byte(8'hC3, 1, a);
        chk(a, "R11 byte survives glitch", a, 1);
        bus_stop();
        chk(mem[5] == 8'hC3, "R11 data intact", mem[5], 8'hC3);

        hc(10);
        chk(exp_q.size() == 0, "R5 all expected writes seen", exp_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule